// File: doc/BRIEF.md
# MDIO Management Interface Master

This block drives the two-wire management bus that a MAC uses to read and write Ethernet PHY registers. It generates the management clock MDC from the system clock and drives or releases the shared data line. The line is split into an output value, an output enable and a returned input, so the pad cell or a board-level tri-state sits outside the block. MDC rests low whenever no transfer is running.

A transfer begins with a one-cycle start strobe, together with a read/write selector, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then sends a full frame: a run of ones, the start pattern, the opcode, both addresses, the turnaround and 16 data bits. On a read it lets go of the line for the turnaround and the data, checks that the PHY pulls the second turnaround bit low, and collects the data. If the PHY does not answer, the block clocks a fixed number of recovery cycles with the line released and finishes with an error. A one-cycle done pulse closes every transfer.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0, done is 0, err is 0 and rd_data is 0.
- R2: Every frame opens with 33 consecutive bits driven as 1. MDC is high for exactly HALF_DIV system clocks and low for HALF_DIV clocks within each bit.
- R3: After the ones the master drives the start pattern 0 then 1, followed by the opcode: 1,0 for a read (rd_req=1) and 0,1 for a write (rd_req=0).
- R4: The PHY address follows the opcode and the register address follows the PHY address. Both are sent with the most significant bit first. All header bits (frame bits 0 to 46) are driven with mdio_oe=1.
- R5: mdio_o and mdio_oe never change while MDC stays high. New bit values appear together with the falling MDC edge or while MDC is low.
- R6: On a write, frame bits 47 and 48 are driven as 1 then 0, and bits 49 to 64 carry wr_data with the most significant bit first.
- R7: On a read, mdio_oe is 0 for frame bits 47 to 64. The line is sampled at the rising MDC edge of bit 48, and it must be 0 there. The 16 data bits (frame bits 49 to 64) are sampled at rising MDC, most significant bit first, and appear on rd_data with done.
- R8: If the line reads 1 at the turnaround sample of a read, the master runs 32 further MDC cycles with mdio_oe=0 and then raises done with err=1. rd_data keeps its previous value.
- R9: done is high for exactly one system clock. In that cycle and afterwards mdc is 0 and mdio_oe is 0.
- R10: A start strobe that arrives while a transfer is running is ignored. The frame in progress keeps its bits and its length.
- R11: err holds its value until the next accepted start, and that start clears it.
- R12: A write or a successful read has 65 MDC cycles, and a failed read has 81. done appears N*2*HALF_DIV+1 clocks after the clock edge that accepts start, where N is the number of MDC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| rd_req | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | PHY_AW | Target PHY address |
| reg_addr | input | REG_AW | Target register address |
| wr_data | input | DATA_W | Data word for a write |
| rd_data | output | DATA_W | Data word of the last successful read |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Turnaround failure of the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The bench sweeps all 32 PHY addresses for writes and for reads and rebuilds each expected frame bit by bit. An address or data word that is reversed or shifted by one bit therefore shows up as a mismatch at a named frame position. Reads whose turnaround stays high check the 81-cycle recovery length, the error flag and the preserved read data. A design that samples the wrong turnaround bit, or that keeps driving during recovery, fails these checks. A start pulse injected halfway through a frame, with every request field inverted, would corrupt the opcode, the addresses or the frame length in a design that accepted it while busy. The error flag is checked both for holding over idle time and for clearing on the next start.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HDR   = 3'd1,
      ST_TA    = 3'd2,
      ST_DATA  = 3'd3,
      ST_RECOV = 3'd4
   } mdio_state_e;

   // fixed frame fields
   localparam logic [1:0] SOF_PAT  = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] TA_DRIVE = 2'b10;

endpackage

// File: rtl/mdio_mdc_timer.sv
// Divides the system clock into MDC bit periods: low half, then high half.
module mdio_mdc_timer #(
   parameter int HALF_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic bit_end
);
   localparam int PER = 2 * HALF_DIV;
   localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("mdio_mdc_timer: HALF_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q, cnt_n;
   logic          last;
   logic          mdc_q;

   always_comb begin
      last  = (cnt_q == CW'(PER - 1));
      cnt_n = last ? '0 : cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (run) begin
         cnt_q <= cnt_n;
         mdc_q <= (cnt_n >= CW'(HALF_DIV));
      end else begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end
   end

   assign mdc       = mdc_q;
   assign rise_tick = run && (cnt_q == CW'(HALF_DIV));
   assign bit_end   = run && last;

endmodule

// File: rtl/mdio_tx_shifter.sv
// Holds the whole outgoing frame and presents its MSB as the current bit.
module mdio_tx_shifter #(
   parameter int FRAME_W = 65
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               shift,
   output logic               bit_out
);
   generate
      if (FRAME_W < 2) begin : g_bad_w
         $error("mdio_tx_shifter: FRAME_W must be at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= frame_in;
      end else if (shift) begin
         sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign bit_out = sr_q[FRAME_W-1];

endmodule

// File: rtl/mdio_rx_capture.sv
// Synchronises the returned line, samples turnaround and data bits.
module mdio_rx_capture #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdio_i,
   input  logic              sample_ta,
   input  logic              sample_data,
   input  logic              commit,
   output logic              ta_high,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("mdio_rx_capture: DATA_W must be at least 2");
      end
   endgenerate

   logic mdio_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign mdio_s = mdio_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '1;
            end else begin
               pipe_q[0] <= mdio_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  pipe_q[i] <= pipe_q[i-1];
               end
            end
         end
         assign mdio_s = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   logic              ta_q;
   logic [DATA_W-1:0] shf_q;
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ta_q  <= 1'b0;
         shf_q <= '0;
         rd_q  <= '0;
      end else begin
         if (sample_ta) begin
            ta_q <= mdio_s;
         end
         if (sample_data) begin
            shf_q <= {shf_q[DATA_W-2:0], mdio_s};
         end
         if (commit) begin
            rd_q <= shf_q;
         end
      end
   end

   assign ta_high = ta_q;
   assign rd_data = rd_q;

endmodule

// File: rtl/mdio_frame_seq.sv
// Walks a transfer through header, turnaround, data or recovery.
module mdio_frame_seq #(
   parameter int HDR_BITS  = 47,
   parameter int DATA_W    = 16,
   parameter int RECOV_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd_req,
   input  logic bit_end,
   input  logic rise_tick,
   input  logic ta_high,
   output logic busy,
   output logic rd_op,
   output logic accept,
   output logic drive_en,
   output logic shift,
   output logic sample_ta,
   output logic sample_data,
   output logic commit,
   output logic done,
   output logic err
);
   import mdio_pkg::*;

   localparam int TA_BITS = 2;
   localparam int MAXB_A  = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
   localparam int MAXB    = (MAXB_A > RECOV_LEN) ? MAXB_A : RECOV_LEN;
   localparam int CNTW    = $clog2(MAXB + 1);

   generate
      if (RECOV_LEN < 1) begin : g_bad_rec
         $error("mdio_frame_seq: RECOV_LEN must be at least 1");
      end
   endgenerate

   mdio_state_e     state_q;
   logic [CNTW-1:0] cnt_q;
   logic            rd_q;
   logic            done_q;
   logic            err_q;

   logic hdr_last, ta_last, data_last, rec_last;

   always_comb begin
      hdr_last  = (cnt_q == CNTW'(HDR_BITS - 1));
      ta_last   = (cnt_q == CNTW'(TA_BITS - 1));
      data_last = (cnt_q == CNTW'(DATA_W - 1));
      rec_last  = (cnt_q == CNTW'(RECOV_LEN - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rd_q    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_HDR;
                  cnt_q   <= '0;
                  rd_q    <= rd_req;
                  err_q   <= 1'b0;
               end
            end
            ST_HDR: begin
               if (bit_end) begin
                  if (hdr_last) begin
                     state_q <= ST_TA;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end
               end
            end
            ST_TA: begin
               if (bit_end) begin
                  if (ta_last) begin
                     cnt_q   <= '0;
                     state_q <= (rd_q && ta_high) ? ST_RECOV : ST_DATA;
                  end else begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  if (data_last) begin
                     state_q <= ST_IDLE;
                     cnt_q   <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end
               end
            end
            ST_RECOV: begin
               if (bit_end) begin
                  if (rec_last) begin
                     state_q <= ST_IDLE;
                     cnt_q   <= '0;
                     done_q  <= 1'b1;
                     err_q   <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   always_comb begin
      busy        = (state_q != ST_IDLE);
      accept      = start && (state_q == ST_IDLE);
      drive_en    = (state_q == ST_HDR) ||
                    (!rd_q && ((state_q == ST_TA) || (state_q == ST_DATA)));
      shift       = bit_end && busy;
      sample_ta   = rise_tick && rd_q && (state_q == ST_TA) && ta_last;
      sample_data = rise_tick && rd_q && (state_q == ST_DATA);
      commit      = bit_end && rd_q && (state_q == ST_DATA) && data_last;
   end

   assign rd_op = rd_q;
   assign done  = done_q;
   assign err   = err_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int HALF_DIV    = 10,
   parameter int PHY_AW      = 5,
   parameter int REG_AW      = 5,
   parameter int DATA_W      = 16,
   parameter int PRE_LEN     = 33,
   parameter int RECOV_LEN   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_req,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              err,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   import mdio_pkg::*;

   localparam int HDR_BITS = PRE_LEN + 4 + PHY_AW + REG_AW;
   localparam int FRAME_W  = HDR_BITS + 2 + DATA_W;

   generate
      if (PHY_AW < 1 || REG_AW < 1) begin : g_bad_aw
         $error("mdio_master: address widths must be at least 1");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("mdio_master: PRE_LEN must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= HALF_DIV) begin : g_bad_sync
         $error("mdio_master: SYNC_STAGES must lie below HALF_DIV");
      end
   endgenerate

   logic busy_w, rd_w, accept_w, drive_w, shift_w;
   logic rise_w, bit_end_w, ta_high_w;
   logic smp_ta_w, smp_data_w, commit_w, tx_bit_w;
   logic [FRAME_W-1:0] frame_w;

   assign frame_w = {{PRE_LEN{1'b1}}, SOF_PAT,
                     (rd_req ? OP_READ : OP_WRITE),
                     phy_addr, reg_addr, TA_DRIVE, wr_data};

   mdio_mdc_timer #(
      .HALF_DIV (HALF_DIV)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_w),
      .mdc       (mdc),
      .rise_tick (rise_w),
      .bit_end   (bit_end_w)
   );

   mdio_frame_seq #(
      .HDR_BITS  (HDR_BITS),
      .DATA_W    (DATA_W),
      .RECOV_LEN (RECOV_LEN)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .rd_req      (rd_req),
      .bit_end     (bit_end_w),
      .rise_tick   (rise_w),
      .ta_high     (ta_high_w),
      .busy        (busy_w),
      .rd_op       (rd_w),
      .accept      (accept_w),
      .drive_en    (drive_w),
      .shift       (shift_w),
      .sample_ta   (smp_ta_w),
      .sample_data (smp_data_w),
      .commit      (commit_w),
      .done        (done),
      .err         (err)
   );

   mdio_tx_shifter #(
      .FRAME_W (FRAME_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept_w),
      .frame_in (frame_w),
      .shift    (shift_w),
      .bit_out  (tx_bit_w)
   );

   mdio_rx_capture #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .mdio_i      (mdio_i),
      .sample_ta   (smp_ta_w),
      .sample_data (smp_data_w),
      .commit      (commit_w),
      .ta_high     (ta_high_w),
      .rd_data     (rd_data)
   );

   assign mdio_oe = drive_w;
   assign mdio_o  = drive_w ? tx_bit_w : 1'b0;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int HALF_DIV = 10
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe,
   input logic done,
   input logic err,
   input logic busy,
   input logic rd_op
);
   logic [31:0] hi_len;
   logic [31:0] lo_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         lo_len <= '0;
      end else begin
         hi_len <= mdc ? hi_len + 32'd1 : 32'd0;
         lo_len <= (busy && !mdc) ? lo_len + 32'd1 : 32'd0;
      end
   end

   // R1: quiet bus whenever no transfer runs
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R2: neither MDC phase outlasts the half period
   a_r2_mdc_high_len: assert property (@(posedge clk) disable iff (!rst_n)
      hi_len <= 32'(HALF_DIV));
   a_r2_mdc_low_len: assert property (@(posedge clk) disable iff (!rst_n)
      lo_len <= 32'(HALF_DIV));

   // R5: line held steady across the high phase
   a_r5_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R8: error only ever follows a read
   a_r8_err_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> rd_op);

   // R9: single-cycle done with the bus parked
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_parked: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mdc && !mdio_oe && !busy));

   // R10: a start while busy leaves the latched operation alone
   a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(rd_op));

   // R11: err moves only at completion or at an accepted start
   a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && !busy) |=> ($stable(err) || done));

endmodule

bind mdio_master mdio_master_chk #(
   .HALF_DIV (HALF_DIV)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .done    (done),
   .err     (err),
   .busy    (busy_w),
   .rd_op   (rd_w)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
   localparam int HALF  = 3;
   localparam int PA    = 5;
   localparam int RA    = 5;
   localparam int DW    = 16;
   localparam int PRE   = 33;
   localparam int REC   = 32;
   localparam int HDR   = PRE + 4 + PA + RA;
   localparam int N_OK  = HDR + 2 + DW;
   localparam int N_BAD = HDR + 2 + REC;
   localparam int LIMIT = 5000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rd_req = 1'b0;
   logic [PA-1:0] phy_addr = '0;
   logic [RA-1:0] reg_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          done, err, mdc, mdio_o, mdio_oe, mdio_i;
   logic          phy_drv = 1'b1;

   always #10 clk = ~clk;

   assign mdio_i = mdio_oe ? mdio_o : phy_drv;

   mdio_master #(.HALF_DIV(HALF)) i_mdio_master (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
      .rd_data(rd_data), .done(done), .err(err), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int total = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus monitor and PHY model
   int       rcount = 0;
   int       base = 0;
   int       hi_run = 0;
   int       bad_hi = 0;
   int       bad_stab = 0;
   logic     rec_o  [256];
   logic     rec_oe [256];
   logic     prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
   logic          m_rd = 1'b0;
   logic          m_ta_ok = 1'b1;
   logic [DW-1:0] m_rdata = '0;

   function automatic logic phy_bit(input int idx);
      if (!m_rd) return 1'b1;
      if (idx == HDR + 1) return m_ta_ok ? 1'b0 : 1'b1;
      if (idx >= HDR + 2 && idx < HDR + 2 + DW) return m_rdata[DW-1-(idx-HDR-2)];
      return 1'b1;
   endfunction

   always @(negedge clk) begin
      if (mdc && !prev_mdc) begin
         if (rcount - base < 256) begin
            rec_o[rcount - base]  = mdio_o;
            rec_oe[rcount - base] = mdio_oe;
         end
         rcount = rcount + 1;
      end
      if (mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe))
         bad_stab = bad_stab + 1;
      if (mdc) hi_run = hi_run + 1;
      else begin
         if (hi_run != 0 && hi_run != HALF) bad_hi = bad_hi + 1;
         hi_run = 0;
         phy_drv = phy_bit(rcount - base);
      end
      prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
   end

   // expected {oe, o} of frame bit idx
   function automatic logic [1:0] exp_bit(input int idx, input logic rd,
         input logic [PA-1:0] pa, input logic [RA-1:0] ra, input logic [DW-1:0] wd);
      int j;
      if (idx < PRE) return 2'b11;
      j = idx - PRE;
      if (j < 2) return {1'b1, (j == 1)};
      if (j < 4) return {1'b1, rd ? (j == 2) : (j == 3)};
      if (j < 4 + PA) return {1'b1, pa[PA-1-(j-4)]};
      if (j < 4 + PA + RA) return {1'b1, ra[RA-1-(j-4-PA)]};
      j = idx - HDR;
      if (rd) return 2'b00;
      if (j == 0) return 2'b11;
      if (j == 1) return 2'b10;
      return {1'b1, wd[DW-1-(j-2)]};
   endfunction

   logic [DW-1:0] last_good = '0;

   task automatic xfer(input logic rd, input logic [PA-1:0] pa, input logic [RA-1:0] ra,
         input logic [DW-1:0] wd, input logic [DW-1:0] rv, input logic ta_ok, input logic poke);
      int n, nb, bad_pre, bad_hdr, bad_tail;
      logic [1:0] e;
      nb = (rd && !ta_ok) ? N_BAD : N_OK;
      @(negedge clk);
      m_rd = rd; m_ta_ok = ta_ok; m_rdata = rv; base = rcount;
      start = 1'b1; rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 1;
      chk(err == 1'b0, "R11 err cleared by accepted start", err, 0);
      while (!done && n < LIMIT) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (poke && n == 100) begin
            // R10: strobe mid-frame with every field inverted
            start = 1'b1; rd_req = !rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
         end else start = 1'b0;
      end
      chk(done == 1'b1, "R12 done reached", done, 1);
      chk(n == nb * 2 * HALF + 1, poke ? "R10 R12 frame duration" : "R12 frame duration",
          n, nb * 2 * HALF + 1);
      chk(rcount - base == nb, "R12 MDC cycle count", rcount - base, nb);
      bad_pre = 0; bad_hdr = 0; bad_tail = 0;
      for (int i = 0; i < nb; i++) begin
         e = exp_bit(i, rd, pa, ra, wd);
         if (rec_oe[i] != e[1] || (e[1] && rec_o[i] != e[0])) begin
            if (i < PRE) bad_pre++;
            else if (i < HDR) bad_hdr++;
            else bad_tail++;
         end
      end
      chk(bad_pre == 0, "R2 preamble of ones", bad_pre, 0);
      chk(bad_hdr == 0, poke ? "R10 R3 R4 header bits" : "R3 R4 header bits", bad_hdr, 0);
      if (!rd)            chk(bad_tail == 0, "R6 write turnaround and data", bad_tail, 0);
      else if (ta_ok)     chk(bad_tail == 0, "R7 released during turnaround and data", bad_tail, 0);
      else                chk(bad_tail == 0, "R8 released during recovery", bad_tail, 0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 bus parked at done", {mdc, mdio_oe}, 0);
      if (rd && ta_ok) begin
         chk(rd_data == rv, "R7 read data", rd_data, rv);
         chk(err == 1'b0, "R7 no error on good read", err, 0);
         last_good = rv;
      end else if (rd) begin
         chk(err == 1'b1, "R8 error on missing turnaround", err, 1);
         chk(rd_data == last_good, "R8 read data kept", rd_data, last_good);
      end else begin
         chk(err == 1'b0, "R6 no error on write", err, 0);
      end
      @(negedge clk);
      chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 bus parked after done", {mdc, mdio_oe}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus idle in reset", {mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(mdc == 1'b0, "R1 mdc low", mdc, 0);
      chk(mdio_oe == 1'b0, "R1 line released", mdio_oe, 0);
      chk(done == 1'b0 && err == 1'b0, "R1 done and err low", {done, err}, 0);
      chk(rd_data == '0, "R1 read data zero", rd_data, 0);

      for (int p = 0; p < 32; p++)
         xfer(1'b0, PA'(p), RA'(31 - p), DW'((p * 2053) ^ 16'hA5C3), '0, 1'b1, 1'b0);
      for (int p = 0; p < 32; p++)
         xfer(1'b1, PA'(p), RA'((p * 7) % 32), '0, DW'((p * 40503) ^ 16'h3C96), 1'b1, 1'b0);

      // R8, R11: failed reads, err holds while idle
      for (int k = 0; k < 4; k++) begin
         xfer(1'b1, PA'(5 + k * 6), RA'(k * 9), '0, DW'(16'hFFFF - k), 1'b0, 1'b0);
         repeat (20) @(negedge clk);
         chk(err == 1'b1, "R11 err held while idle", err, 1);
      end
      // R10: start strobe during a busy write and a busy read
      xfer(1'b0, 5'h15, 5'h0A, 16'hC0DE, '0, 1'b1, 1'b1);
      xfer(1'b1, 5'h0A, 5'h15, '0, 16'h8001, 1'b1, 1'b1);

      chk(bad_hi == 0, "R2 MDC high phase length", bad_hi, 0);
      chk(bad_stab == 0, "R5 line steady while MDC high", bad_stab, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule